// File: doc/BRIEF.md
# Clock Generator Configuration Serial Slave

This block is the two-wire configuration port of a clock generator. A host controller programs a small bank of byte-wide control registers over standard-mode (100 kbit/s) I2C-style traffic. The register contents leave the block as a flat bus to the output-gating logic. Register 0 holds the function and frequency-select bits. Registers 1 to 5 hold one enable bit per clock output: a 1 lets the output run and a 0 holds it low.

There is no register addressing. A write always begins at register 0, and each further data byte goes to the next register. The two bytes that follow the write address are a command code and a byte count. The host must send both, and the block discards both. A read also begins at register 0 and streams the following registers until the host declines a byte. The serial lines are sampled with an oversampling system clock, and the block drives the data line only by pulling it low.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: After reset, register 0 holds 0x00 and registers 1 to 5 hold 0xFF.
- R2: The slave pulls the data line low in the ninth clock after the address byte 0xD2 (write) or 0xD3 (read). Any other address gets no acknowledge, and the slave neither acknowledges nor stores any byte before the next start.
- R3: In a write transaction, every byte after the address is acknowledged, with the data line held low during its ninth clock.
- R4: The first two bytes after a write address (command code, then byte count) change no register.
- R5: The data bytes of a write load registers 0, 1, 2 and onward in order. A stop after any complete byte leaves the remaining registers unchanged.
- R6: Data bytes past the last register are acknowledged and discarded.
- R7: A read sends register 0 first, then the following registers, each byte MSB first. It continues while the host acknowledges (data low in the ninth clock) and releases the line after a host not-acknowledge.
- R8: A read past the last register returns 0xFF.
- R9: A stop condition, including one in the middle of a byte, returns the slave to idle with the data line released. An incomplete byte stores nothing.
- R10: The slave changes its data-line drive only while the synchronized clock line is low, or when it releases the line on a start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line as seen at the pin |
| sdaDrvLow | output | 1 | 1 pulls the data line low (open-drain drive) |
| regBank | output | NUM_REGS*8 | Register contents, register n in bits [8n+7:8n] |

## Verification
The RTL assertions run on every cycle. They check that the drive changes only with the clock low or on a start or stop, that the line is released in idle and after a stop, and that the bit and byte counters stay in range. They also check that a register changes only on a byte-commit strobe from the control. Only the bench scenarios can show the framing and ordering behaviour. That covers discarding the two dummy bytes, loading registers in ascending order, discarding overflow bytes, streaming reads with 0xFF past the end, rejecting a wrong address, and abandoning a partial byte on a stop.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

  typedef struct packed {
    logic xferStart;
    logic rxShift;
    logic rxBit;
    logic commit;
    logic txLoad;
    logic txShift;
  } cfgStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } ctrlState_t;

endpackage

// File: rtl/cfgser_ctrl.sv
module cfgser_ctrl
  import cfgser_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [7:0]  rxByte,
  input  logic        loadMsb,
  input  logic        shiftMsb,
  output cfgStrobes_t stb,
  output logic        sdaOe
);

  localparam int SYNC_STAGES = 2;
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclS, sdaS;
  logic sclRise, sclFall, startDet, stopDet, busy;

  ctrlState_t state;
  logic [3:0] bitCnt;
  logic       isAddr, isRead, masterAck;

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign busy     = ~(startDet | stopDet);

  always_comb begin
    stb.xferStart = startDet;
    stb.rxShift   = busy & (state == ST_RX) & sclRise;
    stb.rxBit     = sdaS;
    stb.commit    = busy & (state == ST_RX) & sclFall & (bitCnt == BITS_PER_BYTE) & ~isAddr;
    stb.txLoad    = busy & sclFall &
                    (((state == ST_ACK) & isRead) | ((state == ST_MACK) & masterAck));
    stb.txShift   = busy & (state == ST_TX) & sclFall & (bitCnt != BITS_PER_BYTE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      isAddr    <= 1'b0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      sdaOe     <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
      sdaOe <= 1'b0;
    end else if (startDet) begin
      state  <= ST_RX;
      bitCnt <= '0;
      isAddr <= 1'b1;
      isRead <= 1'b0;
      sdaOe  <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == BITS_PER_BYTE) begin
            if (!isAddr) begin
              sdaOe <= 1'b1;
              state <= ST_ACK;
            end else if (rxByte[7:1] == DEV_ADDR) begin
              sdaOe  <= 1'b1;
              isRead <= rxByte[0];
              state  <= ST_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            isAddr <= 1'b0;
            bitCnt <= '0;
            if (isRead) begin
              state <= ST_TX;
              sdaOe <= ~loadMsb;
            end else begin
              state <= ST_RX;
              sdaOe <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == BITS_PER_BYTE) begin
              state <= ST_MACK;
              sdaOe <= 1'b0;
            end else begin
              sdaOe <= ~shiftMsb;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            masterAck <= ~sdaS;
          end else if (sclFall) begin
            if (masterAck) begin
              state  <= ST_TX;
              bitCnt <= '0;
              sdaOe  <= ~loadMsb;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R10: drive moves only with the clock low, or is released on start/stop
  a_r10_drive_change_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> (!$past(sclS) || $past(stopDet) || $past(startDet)));

  // R9: a stop always leaves the line released
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopDet) |-> !sdaOe);

  // R2: nothing is driven while idle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);

  // R3: the bit counter never passes one byte
  a_r3_bitcnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BITS_PER_BYTE);

endmodule

// File: rtl/cfgser_datapath.sv
module cfgser_datapath
  import cfgser_pkg::*;
#(
  parameter int NUM_REGS = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfgStrobes_t           stb,
  output logic [7:0]            rxByte,
  output logic                  loadMsb,
  output logic                  shiftMsb,
  output logic [NUM_REGS*8-1:0] regBank
);

  localparam int DUMMY_BYTES = 2;
  localparam int CNT_MAX     = NUM_REGS + DUMMY_BYTES;
  localparam int CNT_W       = $clog2(CNT_MAX + 1);
  localparam int PTR_W       = $clog2(NUM_REGS + 1);

  logic [7:0]       regs [NUM_REGS];
  logic [7:0]       txReg, loadByte;
  logic [CNT_W-1:0] wrCnt;
  logic [PTR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) rxByte <= '0;
    else if (stb.rxShift) rxByte <= {rxByte[6:0], stb.rxBit};
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrCnt <= '0;
    else if (stb.xferStart) wrCnt <= '0;
    else if (stb.commit && wrCnt != CNT_W'(CNT_MAX)) wrCnt <= wrCnt + 1'b1;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      localparam logic [7:0] RST_VAL = (gi == 0) ? 8'h00 : 8'hFF;
      always_ff @(posedge clk) begin
        if (!rstN) regs[gi] <= RST_VAL;
        else if (stb.commit && wrCnt == CNT_W'(gi + DUMMY_BYTES)) regs[gi] <= rxByte;
      end
      assign regBank[gi*8 +: 8] = regs[gi];
    end
  endgenerate

  always_comb begin
    loadByte = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rdPtr == PTR_W'(i)) loadByte = regs[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      txReg <= 8'hFF;
    end else if (stb.xferStart) begin
      rdPtr <= '0;
    end else if (stb.txLoad) begin
      txReg <= loadByte;
      if (rdPtr != PTR_W'(NUM_REGS)) rdPtr <= rdPtr + 1'b1;
    end else if (stb.txShift) begin
      txReg <= {txReg[6:0], 1'b1};
    end
  end

  assign loadMsb  = loadByte[7];
  assign shiftMsb = txReg[6];

  // R5: a register moves only on a commit strobe from the control
  a_r5_regs_change_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    (regBank != $past(regBank)) |-> $past(stb.commit));

  // R6: the write counter saturates instead of wrapping
  a_r6_wrcnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt <= CNT_W'(CNT_MAX));

  // R8: the read pointer parks one past the last register
  a_r8_rdptr_bound: assert property (@(posedge clk) disable iff (!rstN)
    rdPtr <= PTR_W'(NUM_REGS));

endmodule

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave
  import cfgser_pkg::*;
#(
  parameter int         NUM_REGS = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDrvLow,
  output logic [NUM_REGS*8-1:0] regBank
);

  cfgStrobes_t stb;
  logic [7:0]  rxByte;
  logic        loadMsb, shiftMsb;

  cfgser_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .rxByte   (rxByte),
    .loadMsb  (loadMsb),
    .shiftMsb (shiftMsb),
    .stb      (stb),
    .sdaOe    (sdaDrvLow)
  );

  cfgser_datapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rxByte   (rxByte),
    .loadMsb  (loadMsb),
    .shiftMsb (shiftMsb),
    .regBank  (regBank)
  );

endmodule

// File: tb/clkcfg_serial_slave_bench.sv
module clkcfg_serial_slave_bench;

  localparam int NREG = 6;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaDrvLow;
  logic sdaLine;
  logic [NREG*8-1:0] regBank;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] expRegs [NREG];
  logic [7:0] wbuf [16];

  always #5 clk = ~clk;

  assign sdaLine = sdaM & ~sdaDrvLow;

  clkcfg_serial_slave u_clkcfg_serial_slave (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclM),
    .sdaIn     (sdaLine),
    .sdaDrvLow (sdaDrvLow),
    .regBank   (regBank)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; waitq();
    sdaM = 1'b0; waitq();
    sclM = 1'b0; waitq();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitq();
    sclM = 1'b1; waitq();
    sdaM = 1'b1; waitq();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitq();
    sclM = 1'b1; waitq(); waitq();
    sclM = 1'b0; waitq();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; waitq();
    sclM = 1'b1; waitq();
    ack = ~sdaLine;
    waitq();
    sclM = 1'b0; waitq();
  endtask

  task automatic readByte(input logic mack, output logic [7:0] b);
    sdaM = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      waitq();
      sclM = 1'b1; waitq();
      b = {b[6:0], sdaLine};
      waitq();
      sclM = 1'b0;
    end
    sdaM = ~mack; waitq();
    sclM = 1'b1; waitq(); waitq();
    sclM = 1'b0; waitq();
    sdaM = 1'b1;
  endtask

  task automatic checkRegs(input string req);
    for (int i = 0; i < NREG; i++) chk(req, int'(regBank[i*8 +: 8]), int'(expRegs[i]));
  endtask

  // Write: address 0xD2, two dummy bytes, then n data bytes from wbuf
  task automatic writeTxn(input logic [7:0] cmd, input logic [7:0] cnt, input int n);
    logic ack;
    busStart();
    sendByte(8'hD2, ack); chk("R2 write address ack", int'(ack), 1);
    sendByte(cmd, ack);   chk("R3 command byte ack", int'(ack), 1);
    sendByte(cnt, ack);   chk("R3 count byte ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], ack);
      chk(i < NREG ? "R3 data byte ack" : "R6 overflow byte ack", int'(ack), 1);
      if (i < NREG) expRegs[i] = wbuf[i];
    end
    busStop();
    checkRegs("R4 R5 R6 register contents");
  endtask

  // Read: address 0xD3, then n bytes, not-acknowledging the last
  task automatic readTxn(input int n);
    logic ack;
    logic [7:0] b;
    busStart();
    sendByte(8'hD3, ack); chk("R2 read address ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      readByte(i < n - 1, b);
      if (i < NREG) chk("R7 read byte", int'(b), int'(expRegs[i]));
      else          chk("R8 read past end", int'(b), 'hFF);
    end
    chk("R7 line released after not-ack", int'(sdaDrvLow), 0);
    busStop();
  endtask

  initial begin
    logic ack;
    for (int i = 0; i < NREG; i++) expRegs[i] = (i == 0) ? 8'h00 : 8'hFF;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1: power-on contents
    checkRegs("R1 reset value");
    chk("R1 line released after reset", int'(sdaDrvLow), 0);
    readTxn(NREG + 2);

    // R4 R5 R6 R7 R8: sweep over data-byte counts and patterns
    for (int k = 0; k < 12; k++) begin
      int n;
      n = k % 10;
      for (int i = 0; i < 16; i++) wbuf[i] = 8'((k * 53 + i * 29 + 7) & 'hFF);
      writeTxn(8'(8'hA5 ^ k), 8'(k * 17), n);
      readTxn((k % 3 == 0) ? 1 : NREG + 2);
    end

    // R2: foreign addresses get no acknowledge and store nothing
    busStart();
    sendByte(8'hA4, ack); chk("R2 foreign address nack", int'(ack), 0);
    sendByte(8'h00, ack); chk("R2 no ack after foreign address", int'(ack), 0);
    sendByte(8'h11, ack); chk("R2 no ack after foreign address", int'(ack), 0);
    busStop();
    busStart();
    sendByte(8'hD0, ack); chk("R2 near-miss address nack", int'(ack), 0);
    busStop();
    checkRegs("R2 registers untouched");

    // R9: stop in the middle of a data byte
    busStart();
    sendByte(8'hD2, ack); chk("R2 write address ack", int'(ack), 1);
    sendByte(8'h00, ack);
    sendByte(8'h00, ack);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    busStop();
    chk("R9 line released after stop", int'(sdaDrvLow), 0);
    checkRegs("R9 partial byte stores nothing");
    readTxn(NREG + 1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule